// File: doc/BRIEF.md
# Predicated Integer Execute Stage

This block is the decode and execute step for a 32-bit instruction word in which every instruction is guarded by one of sixteen one-bit predicate flags. It holds thirty-two 32-bit general registers and the predicate flags. In one cycle it decodes the word, reads its operands and computes a result. If the guarding flag is set, it commits that result at the next rising clock edge.

Three instruction families are handled:

- register-register arithmetic, logic and shift operations;
- the same arithmetic and logic with a 13-bit immediate;
- compares, which write a predicate flag instead of a general register.

Each write is also presented on a write-back port, so a register or flag written by one instruction is visible to the next. Every other opcode or function code leaves all state untouched.

Top module: `pred_exec_unit`

## Requirements
- R1: After reset every general register reads zero, predicate flags 1 to 15 read false and flag 0 reads true.
- R2: With major opcode [27:23] = 00010, the target is [22:18], source A is [17:13], source B is [12:8] and the function is [7:0]. The function codes are ADD 0x04, SUB 0x05, AND 0x08, OR 0x09 and XOR 0x0A; each writes A op B to the target.
- R3: Function 0x10 shifts A left, 0x11 shifts it right with zero fill and 0x12 shifts it right with sign fill. The shift amount is the low 5 bits of B.
- R4: Major opcodes 00100, 01000, 01001 and 01010 write A plus, AND, OR or XOR a 13-bit immediate [12:0] to the target. The immediate is sign-extended for the add and zero-extended for the three logic forms.
- R5: A register-register function 1111cccc is a compare of A with B that writes predicate flag [21:18]. The condition code cccc selects: 0 equal, 1 not equal, 2 signed less than, 3 signed greater or equal, 4 unsigned less than, 5 unsigned greater or equal.
- R6: Condition code 6 writes the carry out of A+B. Codes 7 to 15 write false, and the write still takes place.
- R7: Bits [31:28] select the guarding flag. When that flag is false, no write-back strobe is raised and no register or flag changes.
- R8: Flag 0 always reads true, so selector 0 means always execute. A compare targeting flag 0 raises no strobe and has no effect.
- R9: Register 0 always reads zero. A write to it raises no strobe and has no effect.
- R10: Any other major opcode or register-register function code, including the no-op function 0xEA, raises no strobe and changes no state.
- R11: State written by an instruction is seen by the next instruction. A compare guarded by the flag it writes is judged on the flag's value before the write.
- R12: While instrValid is low, no strobe is raised and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state commits on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| wbEn | output | 1 | General register write committed this cycle |
| wbAddr | output | 5 | Register being written |
| wbData | output | 32 | Value being written |
| prWbEn | output | 1 | Predicate flag write committed this cycle |
| prWbAddr | output | 4 | Predicate flag being written |
| prWbVal | output | 1 | Value written to the flag |

## Verification
Two operations can meet in one cycle: reading the guarding flag and writing a compare result to that same flag. The bench sets a flag true, then issues a compare guarded by that flag which writes false into it. It then re-issues the compare with the flag now false. The first compare must raise its strobe, because it is judged on the old value. The second must not, and a later read must show the false value. Back-to-back register-register instructions, where one consumes the other's target, check the same forwarding of state through the clock edge for general registers.

// File: rtl/pexec_pkg.sv
package pexec_pkg;

  // instruction field widths
  localparam int PRED_FW = 4;
  localparam int OPC_W   = 5;
  localparam int REG_FW  = 5;
  localparam int FN_W    = 8;
  localparam int IMM_W   = 13;

  // major opcodes
  localparam logic [OPC_W-1:0] OPC_REGREG = 5'b00010;
  localparam logic [OPC_W-1:0] OPC_ADDIMM = 5'b00100;
  localparam logic [OPC_W-1:0] OPC_ANDIMM = 5'b01000;
  localparam logic [OPC_W-1:0] OPC_ORIMM  = 5'b01001;
  localparam logic [OPC_W-1:0] OPC_XORIMM = 5'b01010;

  // register-register function codes
  localparam logic [FN_W-1:0] FN_ADD = 8'h04;
  localparam logic [FN_W-1:0] FN_SUB = 8'h05;
  localparam logic [FN_W-1:0] FN_AND = 8'h08;
  localparam logic [FN_W-1:0] FN_OR  = 8'h09;
  localparam logic [FN_W-1:0] FN_XOR = 8'h0A;
  localparam logic [FN_W-1:0] FN_SHL = 8'h10;
  localparam logic [FN_W-1:0] FN_SHR = 8'h11;
  localparam logic [FN_W-1:0] FN_SAR = 8'h12;
  localparam logic [3:0]      FN_CMP_HI = 4'hF;

  // compare conditions
  localparam logic [3:0] CC_EQ  = 4'd0;
  localparam logic [3:0] CC_NE  = 4'd1;
  localparam logic [3:0] CC_SLT = 4'd2;
  localparam logic [3:0] CC_SGE = 4'd3;
  localparam logic [3:0] CC_ULT = 4'd4;
  localparam logic [3:0] CC_UGE = 4'd5;
  localparam logic [3:0] CC_CRY = 4'd6;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SHL, ALU_SHR, ALU_SAR
  } aluOpT;

  // strobes from control to datapath
  typedef struct packed {
    logic       regWr;
    logic       predWr;
    aluOpT      aluOp;
    logic       useImm;
    logic       immSext;
    logic [3:0] cmpCode;
  } ctrlT;

endpackage

// File: rtl/pexec_ctrl.sv
module pexec_ctrl
  import pexec_pkg::*;
(
  input  logic             instrValid,
  input  logic [OPC_W-1:0] opc,
  input  logic [FN_W-1:0]  fn,
  input  logic [REG_FW-1:0] rt,
  input  logic             guardTrue,
  output ctrlT             ctrl
);

  logic wantReg;
  logic wantPred;
  logic commit;
  logic [PRED_FW-1:0] pd;

  assign pd     = rt[PRED_FW-1:0];
  assign commit = instrValid && guardTrue;

  always_comb begin
    ctrl     = '0;
    ctrl.aluOp = ALU_ADD;
    wantReg  = 1'b0;
    wantPred = 1'b0;
    unique case (opc)
      OPC_REGREG: begin
        if (fn[FN_W-1:4] == FN_CMP_HI) begin
          wantPred     = 1'b1;
          ctrl.cmpCode = fn[3:0];
        end else begin
          wantReg = 1'b1;
          case (fn)
            FN_ADD:  ctrl.aluOp = ALU_ADD;
            FN_SUB:  ctrl.aluOp = ALU_SUB;
            FN_AND:  ctrl.aluOp = ALU_AND;
            FN_OR:   ctrl.aluOp = ALU_OR;
            FN_XOR:  ctrl.aluOp = ALU_XOR;
            FN_SHL:  ctrl.aluOp = ALU_SHL;
            FN_SHR:  ctrl.aluOp = ALU_SHR;
            FN_SAR:  ctrl.aluOp = ALU_SAR;
            default: wantReg = 1'b0;
          endcase
        end
      end
      OPC_ADDIMM: begin
        wantReg = 1'b1; ctrl.useImm = 1'b1; ctrl.immSext = 1'b1;
        ctrl.aluOp = ALU_ADD;
      end
      OPC_ANDIMM: begin
        wantReg = 1'b1; ctrl.useImm = 1'b1; ctrl.aluOp = ALU_AND;
      end
      OPC_ORIMM: begin
        wantReg = 1'b1; ctrl.useImm = 1'b1; ctrl.aluOp = ALU_OR;
      end
      OPC_XORIMM: begin
        wantReg = 1'b1; ctrl.useImm = 1'b1; ctrl.aluOp = ALU_XOR;
      end
      default: ;
    endcase
    ctrl.regWr  = wantReg  && commit && (rt != '0);
    ctrl.predWr = wantPred && commit && (pd != '0);
  end

endmodule

// File: rtl/pexec_datapath.sv
module pexec_datapath
  import pexec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlT               ctrl,
  input  logic [PRED_FW-1:0] guardSel,
  input  logic [REG_FW-1:0]  rt,
  input  logic [REG_FW-1:0]  ra,
  input  logic [IMM_W-1:0]   imm,
  output logic               guardTrue,
  output logic               wbEn,
  output logic [REG_FW-1:0]  wbAddr,
  output logic [XLEN-1:0]    wbData,
  output logic               prWbEn,
  output logic [PRED_FW-1:0] prWbAddr,
  output logic               prWbVal
);

  localparam int NREG    = 1 << REG_FW;
  localparam int NPRED   = 1 << PRED_FW;
  localparam int SHAMT_W = $clog2(XLEN);

  logic [XLEN-1:0]  gpr [NREG];
  logic [NPRED-1:0] pflag;

  logic [REG_FW-1:0]  rb;
  logic [XLEN-1:0]    rdA, rdB, opB, aluRes;
  logic [SHAMT_W-1:0] shamt;
  logic [XLEN:0]      carrySum;
  logic               cmpRes;

  assign rb  = imm[IMM_W-1 -: REG_FW];
  // entry 0 is never written, so it keeps its reset value of zero
  assign rdA = gpr[ra];
  assign rdB = gpr[rb];
  // flag 0 is never written, so it keeps its reset value of one
  assign guardTrue = pflag[guardSel];

  always_comb begin
    if (!ctrl.useImm)      opB = rdB;
    else if (ctrl.immSext) opB = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    else                   opB = {{(XLEN-IMM_W){1'b0}}, imm};
  end

  assign shamt = opB[SHAMT_W-1:0];

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD: aluRes = rdA + opB;
      ALU_SUB: aluRes = rdA - opB;
      ALU_AND: aluRes = rdA & opB;
      ALU_OR:  aluRes = rdA | opB;
      ALU_XOR: aluRes = rdA ^ opB;
      ALU_SHL: aluRes = rdA << shamt;
      ALU_SHR: aluRes = rdA >> shamt;
      ALU_SAR: aluRes = $unsigned($signed(rdA) >>> shamt);
      default: aluRes = '0;
    endcase
  end

  assign carrySum = {1'b0, rdA} + {1'b0, rdB};

  always_comb begin
    case (ctrl.cmpCode)
      CC_EQ:   cmpRes = (rdA == rdB);
      CC_NE:   cmpRes = (rdA != rdB);
      CC_SLT:  cmpRes = ($signed(rdA) <  $signed(rdB));
      CC_SGE:  cmpRes = ($signed(rdA) >= $signed(rdB));
      CC_ULT:  cmpRes = (rdA <  rdB);
      CC_UGE:  cmpRes = (rdA >= rdB);
      CC_CRY:  cmpRes = carrySum[XLEN];
      default: cmpRes = 1'b0;
    endcase
  end

  assign wbEn     = ctrl.regWr;
  assign wbAddr   = rt;
  assign wbData   = aluRes;
  assign prWbEn   = ctrl.predWr;
  assign prWbAddr = rt[PRED_FW-1:0];
  assign prWbVal  = cmpRes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
    end else if (ctrl.regWr) begin
      gpr[rt] <= aluRes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pflag <= {{(NPRED-1){1'b0}}, 1'b1};
    end else if (ctrl.predWr) begin
      pflag[rt[PRED_FW-1:0]] <= cmpRes;
    end
  end

endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit
  import pexec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [31:0]        instr,
  output logic               wbEn,
  output logic [REG_FW-1:0]  wbAddr,
  output logic [XLEN-1:0]    wbData,
  output logic               prWbEn,
  output logic [PRED_FW-1:0] prWbAddr,
  output logic               prWbVal
);

  ctrlT ctrl;
  logic guardTrue;

  pexec_ctrl u_ctrl (
    .instrValid (instrValid),
    .opc        (instr[27:23]),
    .fn         (instr[7:0]),
    .rt         (instr[22:18]),
    .guardTrue  (guardTrue),
    .ctrl       (ctrl)
  );

  pexec_datapath #(.XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .guardSel  (instr[31:28]),
    .rt        (instr[22:18]),
    .ra        (instr[17:13]),
    .imm       (instr[12:0]),
    .guardTrue (guardTrue),
    .wbEn      (wbEn),
    .wbAddr    (wbAddr),
    .wbData    (wbData),
    .prWbEn    (prWbEn),
    .prWbAddr  (prWbAddr),
    .prWbVal   (prWbVal)
  );

endmodule

// File: rtl/pexec_checker.sv
module pexec_checker (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [31:0] instr,
  input logic        guardTrue,
  input logic        wbEn,
  input logic [4:0]  wbAddr,
  input logic        prWbEn,
  input logic [3:0]  prWbAddr,
  input logic        prWbVal
);

  assert_unguarded_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !guardTrue |-> (!wbEn && !prWbEn));

  assert_p0_always_true_R8: assert property (@(posedge clk) disable iff (!rstN)
    (instr[31:28] == 4'd0) |-> guardTrue);

  assert_p0_never_written_R8: assert property (@(posedge clk) disable iff (!rstN)
    prWbEn |-> (prWbAddr != 4'd0));

  assert_r0_never_written_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (wbAddr != 5'd0));

  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(wbEn && prWbEn));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> (!wbEn && !prWbEn));

  assert_pred_visible_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(prWbEn) && (instr[31:28] == $past(prWbAddr)))
      |-> (guardTrue == $past(prWbVal)));

endmodule

bind pred_exec_unit pexec_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .instr      (instr),
  .guardTrue  (guardTrue),
  .wbEn       (wbEn),
  .wbAddr     (wbAddr),
  .prWbEn     (prWbEn),
  .prWbAddr   (prWbAddr),
  .prWbVal    (prWbVal)
);

// File: tb/tb_pred_exec_unit.sv
`timescale 1ns/1ps
module tb_pred_exec_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instr = '0;
  logic        wbEn, prWbEn, prWbVal;
  logic [4:0]  wbAddr;
  logic [3:0]  prWbAddr;
  logic [31:0] wbData;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pred_exec_unit dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData),
    .prWbEn(prWbEn), .prWbAddr(prWbAddr), .prWbVal(prWbVal)
  );

  localparam logic [4:0] OP_RR = 5'b00010, OP_ADDI = 5'b00100, OP_ANDI = 5'b01000,
                         OP_ORI = 5'b01001, OP_XORI = 5'b01010;
  localparam logic [31:0] VA = 32'd100, VB = 32'hFFFF_FFFD;

  function automatic logic [31:0] encRR(logic [3:0] p, logic [4:0] rt, logic [4:0] ra,
                                        logic [4:0] rb, logic [7:0] fn);
    return {p, OP_RR, rt, ra, rb, fn};
  endfunction

  function automatic logic [31:0] encImm(logic [3:0] p, logic [4:0] op, logic [4:0] rt,
                                         logic [4:0] ra, logic [12:0] imm);
    return {p, op, rt, ra, imm};
  endfunction

  function automatic logic [31:0] encCmp(logic [3:0] p, logic [3:0] pd, logic [4:0] ra,
                                         logic [4:0] rb, logic [3:0] cc);
    return {p, OP_RR, 1'b0, pd, ra, rb, 4'hF, cc};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, outputs settle 1 ns later, state commits at the next rising edge
  task automatic issue(logic [31:0] w, logic v = 1'b1);
    @(negedge clk);
    instr = w;
    instrValid = v;
    #1;
  endtask

  task automatic readReg(logic [4:0] r, output logic [31:0] val);
    issue(encImm(4'd0, OP_ADDI, 5'd30, r, 13'd0));
    val = wbData;
  endtask

  task automatic readPred(logic [3:0] p, output logic val);
    issue(encImm(p, OP_ADDI, 5'd30, 5'd0, 13'd0));
    val = wbEn;
  endtask

  task automatic setReg(logic [4:0] r, logic [12:0] imm);
    issue(encImm(4'd0, OP_ADDI, r, 5'd0, imm));
  endtask

  task automatic testReset();
    logic [31:0] v; logic b;
    readReg(5'd5, v);  check("R1 reg5 zero", v, 32'd0);
    readPred(4'd3, b); check("R1 p3 false", {31'd0, b}, 32'd0);
    readPred(4'd0, b); check("R1 p0 true", {31'd0, b}, 32'd1);
  endtask

  task automatic testRegReg();
    setReg(5'd1, 13'd100);
    setReg(5'd2, 13'h1FFD);
    issue(encRR(4'd0, 5'd10, 5'd1, 5'd2, 8'h04));
    check("R2 ADD en", {31'd0, wbEn}, 32'd1);
    check("R2 ADD addr", {27'd0, wbAddr}, 32'd10);
    check("R2 ADD", wbData, VA + VB);
    issue(encRR(4'd0, 5'd10, 5'd1, 5'd2, 8'h05)); check("R2 SUB", wbData, VA - VB);
    issue(encRR(4'd0, 5'd10, 5'd1, 5'd2, 8'h08)); check("R2 AND", wbData, VA & VB);
    issue(encRR(4'd0, 5'd10, 5'd1, 5'd2, 8'h09)); check("R2 OR", wbData, VA | VB);
    issue(encRR(4'd0, 5'd10, 5'd1, 5'd2, 8'h0A)); check("R2 XOR", wbData, VA ^ VB);
  endtask

  task automatic testShift();
    setReg(5'd3, 13'h1FF8);   // -8
    setReg(5'd4, 13'd33);     // low 5 bits = 1
    issue(encRR(4'd0, 5'd10, 5'd3, 5'd4, 8'h10)); check("R3 SHL", wbData, 32'hFFFF_FFF0);
    issue(encRR(4'd0, 5'd10, 5'd3, 5'd4, 8'h11)); check("R3 SHR", wbData, 32'h7FFF_FFFC);
    issue(encRR(4'd0, 5'd10, 5'd3, 5'd4, 8'h12)); check("R3 ASR", wbData, 32'hFFFF_FFFC);
  endtask

  task automatic testImm();
    issue(encImm(4'd0, OP_ADDI, 5'd5, 5'd1, 13'h1000));
    check("R4 ADDi sext", wbData, VA - 32'd4096);
    issue(encImm(4'd0, OP_ANDI, 5'd6, 5'd2, 13'h1FFF));
    check("R4 ANDi zext", wbData, VB & 32'h1FFF);
    issue(encImm(4'd0, OP_ORI, 5'd7, 5'd0, 13'h1000));
    check("R4 ORi zext", wbData, 32'h1000);
    issue(encImm(4'd0, OP_XORI, 5'd8, 5'd2, 13'h1FFF));
    check("R4 XORi zext", wbData, VB ^ 32'h1FFF);
  endtask

  task automatic testCompare();
    logic b;
    issue(encCmp(4'd0, 4'd5, 5'd1, 5'd1, 4'd0));
    check("R5 EQ en", {31'd0, prWbEn}, 32'd1);
    check("R5 EQ addr", {28'd0, prWbAddr}, 32'd5);
    check("R5 EQ", {31'd0, prWbVal}, 32'd1);
    issue(encCmp(4'd0, 4'd6, 5'd1, 5'd2, 4'd1)); check("R5 NE", {31'd0, prWbVal}, 32'd1);
    issue(encCmp(4'd0, 4'd7, 5'd2, 5'd1, 4'd2)); check("R5 SLT", {31'd0, prWbVal}, 32'd1);
    issue(encCmp(4'd0, 4'd8, 5'd2, 5'd1, 4'd3)); check("R5 SGE", {31'd0, prWbVal}, 32'd0);
    issue(encCmp(4'd0, 4'd9, 5'd2, 5'd1, 4'd4)); check("R5 ULT", {31'd0, prWbVal}, 32'd0);
    issue(encCmp(4'd0, 4'd10, 5'd2, 5'd1, 4'd5)); check("R5 UGE", {31'd0, prWbVal}, 32'd1);
    readPred(4'd7, b); check("R5 p7 stored", {31'd0, b}, 32'd1);
  endtask

  task automatic testCarry();
    setReg(5'd9, 13'h1FFF);   // all ones
    issue(encCmp(4'd0, 4'd11, 5'd9, 5'd9, 4'd6)); check("R6 carry set", {31'd0, prWbVal}, 32'd1);
    issue(encCmp(4'd0, 4'd12, 5'd1, 5'd1, 4'd6)); check("R6 carry clear", {31'd0, prWbVal}, 32'd0);
    issue(encCmp(4'd0, 4'd13, 5'd1, 5'd1, 4'd9));
    check("R6 code9 en", {31'd0, prWbEn}, 32'd1);
    check("R6 code9 false", {31'd0, prWbVal}, 32'd0);
  endtask

  task automatic testGuard();
    logic [31:0] v; logic b;
    issue(encCmp(4'd0, 4'd2, 5'd1, 5'd2, 4'd0));   // p2 := false
    issue(encImm(4'd2, OP_ADDI, 5'd10, 5'd0, 13'd5));
    check("R7 guarded off no wb", {31'd0, wbEn}, 32'd0);
    issue(encRR(4'd0, 5'd10, 5'd0, 5'd0, 8'h04));  // r10 := 0
    issue(encImm(4'd2, OP_ADDI, 5'd10, 5'd0, 13'd5));
    readReg(5'd10, v); check("R7 reg unchanged", v, 32'd0);
    issue(encCmp(4'd2, 4'd3, 5'd1, 5'd1, 4'd0));
    check("R7 guarded cmp no wb", {31'd0, prWbEn}, 32'd0);
    readPred(4'd3, b); check("R7 pred unchanged", {31'd0, b}, 32'd0);
    issue(encCmp(4'd0, 4'd3, 5'd1, 5'd1, 4'd0));   // p3 := true
    issue(encImm(4'd3, OP_ADDI, 5'd10, 5'd0, 13'd5));
    check("R7 guarded on wb", {31'd0, wbEn}, 32'd1);
    readReg(5'd10, v); check("R7 reg written", v, 32'd5);
  endtask

  task automatic testP0();
    logic b;
    issue(encCmp(4'd0, 4'd0, 5'd1, 5'd2, 4'd0));
    check("R8 p0 write no strobe", {31'd0, prWbEn}, 32'd0);
    readPred(4'd0, b); check("R8 p0 still true", {31'd0, b}, 32'd1);
  endtask

  task automatic testR0();
    logic [31:0] v;
    issue(encImm(4'd0, OP_ADDI, 5'd0, 5'd0, 13'd7));
    check("R9 r0 write no strobe", {31'd0, wbEn}, 32'd0);
    readReg(5'd0, v); check("R9 r0 zero", v, 32'd0);
  endtask

  task automatic testUnsupported();
    logic [31:0] v;
    issue(encRR(4'd0, 5'd0, 5'd0, 5'd0, 8'hEA));
    check("R10 NOP quiet", {30'd0, wbEn, prWbEn}, 32'd0);
    issue(encRR(4'd0, 5'd11, 5'd1, 5'd2, 8'h0B));
    check("R10 fn 0x0B quiet", {30'd0, wbEn, prWbEn}, 32'd0);
    issue(encImm(4'd0, 5'b10000, 5'd11, 5'd1, 13'd5));
    check("R10 opcode 10000 quiet", {30'd0, wbEn, prWbEn}, 32'd0);
    readReg(5'd11, v); check("R10 r11 untouched", v, 32'd0);
  endtask

  task automatic testSameCycle();
    logic b;
    issue(encCmp(4'd0, 4'd4, 5'd1, 5'd1, 4'd0));   // p4 := true
    issue(encCmp(4'd4, 4'd4, 5'd1, 5'd1, 4'd1));   // guarded by p4, writes false
    check("R11 old guard used", {31'd0, prWbEn}, 32'd1);
    check("R11 value false", {31'd0, prWbVal}, 32'd0);
    issue(encCmp(4'd4, 4'd4, 5'd1, 5'd1, 4'd0));
    check("R11 new guard seen", {31'd0, prWbEn}, 32'd0);
    readPred(4'd4, b); check("R11 p4 false", {31'd0, b}, 32'd0);
    setReg(5'd12, 13'd9);
    issue(encRR(4'd0, 5'd13, 5'd12, 5'd12, 8'h04));
    check("R11 back to back", wbData, 32'd18);
  endtask

  task automatic testValid();
    logic [31:0] v;
    issue(encImm(4'd0, OP_ADDI, 5'd14, 5'd0, 13'd3), 1'b0);
    check("R12 invalid quiet", {30'd0, wbEn, prWbEn}, 32'd0);
    readReg(5'd14, v); check("R12 r14 untouched", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegReg();
    testShift();
    testImm();
    testCompare();
    testCarry();
    testGuard();
    testP0();
    testR0();
    testUnsupported();
    testSameCycle();
    testValid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule